// File: doc/BRIEF.md
# Branch Target Cache

This block is a small, fully associative store that remembers the targets of branches expected to be taken. The fetch unit presents its current fetch address on the lookup port. When the address belongs to a remembered branch, the block reports a hit and returns the stored target in the same cycle. The fetch unit can then redirect on the next fetch without losing a cycle.

Branch direction is decided elsewhere. The block is told about each branch through an update port, which carries the branch address, its target and whether that branch is now expected to be taken. Only branches expected to be taken are stored. A branch that turns to not-taken is removed from the store. When the store is full, a round-robin pointer chooses which entry a new branch replaces. An empty slot is always used before any entry is replaced.

Top module: `btc_top`

## Requirements
- R1: After reset every entry is invalid, so a lookup of any address reports no hit.
- R2: A taken update for an address that is not stored allocates an entry. From the next cycle on, a lookup of that address hits and returns the target that was written.
- R3: The lookup is combinational. `lk_hit` and `lk_target` follow `lk_addr` within the same cycle, with no clock edge in between.
- R4: A not-taken update for an address that is not stored has no effect. A later lookup of that address misses, and no stored entry is disturbed.
- R5: A not-taken update for a stored address invalidates that entry. A lookup of the address misses from the next cycle on.
- R6: A taken update for an address that is already stored overwrites that entry's target and does not create a second entry. A single not-taken update for the address is therefore enough to make its lookups miss.
- R7: When at least one entry is invalid, an allocation uses the lowest-numbered invalid entry. It does not evict a valid entry and it does not move the round-robin pointer.
- R8: When every entry is valid, an allocation replaces the entry named by the round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping at the last entry, on each such replacement. Entries are filled in index order from an empty store.
- R9: When an update and a lookup concern the same entry in the same cycle, the lookup returns the contents the entry had before that update.
- R10: The match uses the full branch address. An address that differs from a stored one in any single bit misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_addr | input | ADDR_W | Fetch address to look up |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_target | output | ADDR_W | Stored target of the matching entry, zero on a miss |
| upd_valid | input | 1 | An update is presented this cycle |
| upd_addr | input | ADDR_W | Address of the branch being updated |
| upd_target | input | ADDR_W | Target of the branch being updated |
| upd_taken | input | 1 | 1: branch now expected taken, 0: expected not taken |

## Verification
A lookup and an update can reach the same entry in one cycle, and the lookup must still see the entry's old contents. The bench provokes this by setting `lk_addr` and the update inputs together between edges. It first checks that the lookup returns the old target, or still hits for an entry being removed, before the edge. It then checks the new state after the edge. Both an overwrite of the target and an invalidation are exercised in this way.

// File: rtl/btc_pkg.sv
package btc_pkg;

    typedef enum logic [1:0] {
        UPD_NONE    = 2'd0,
        UPD_REFRESH = 2'd1,
        UPD_ALLOC   = 2'd2,
        UPD_DROP    = 2'd3
    } upd_kind_e;

    // Decide what an update request does to the store.
    function automatic upd_kind_e btc_classify(input logic req,
                                               input logic taken,
                                               input logic hit);
        if (!req) begin
            return UPD_NONE;
        end
        if (taken) begin
            return hit ? UPD_REFRESH : UPD_ALLOC;
        end
        return hit ? UPD_DROP : UPD_NONE;
    endfunction

endpackage

// File: rtl/btc_cam.sv
module btc_cam #(
    parameter int N  = 32,
    parameter int AW = 32
) (
    input  logic [N-1:0]         valid,
    input  logic [N-1:0][AW-1:0] tags,
    input  logic [AW-1:0]        key,
    output logic [N-1:0]         match
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end
endmodule

// File: rtl/btc_enc.sv
module btc_enc #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  onehot,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) begin
                idx = idx | IW'(i);
            end
        end
    end
endmodule

// File: rtl/btc_victim.sv
module btc_victim #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  valid,
    input  logic          alloc,
    output logic [IW-1:0] victim_idx,
    output logic [IW-1:0] rr_ptr
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic          free_found;
    logic [IW-1:0] free_idx;
    logic [IW-1:0] rr_q;

    // Lowest-numbered invalid entry.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_found = 1'b1;
                free_idx   = IW'(i);
            end
        end
    end

    assign victim_idx = free_found ? free_idx : rr_q;
    assign rr_ptr     = rr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (alloc && !free_found) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/btc_top.sv
module btc_top
    import btc_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int ADDR_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_target,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              upd_taken
);
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    logic [NUM_ENTRIES-1:0]             valid_q;
    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] tag_q;
    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] tgt_q;

    logic [NUM_ENTRIES-1:0] lk_match;
    logic [NUM_ENTRIES-1:0] upd_match;
    logic                   upd_hit;
    logic [IDX_W-1:0]       upd_idx;
    logic [IDX_W-1:0]       victim_idx;
    logic [IDX_W-1:0]       rr_ptr;
    upd_kind_e              upd_kind;

    btc_cam #(.N(NUM_ENTRIES), .AW(ADDR_W)) u_lk_cam (
        .valid (valid_q),
        .tags  (tag_q),
        .key   (lk_addr),
        .match (lk_match)
    );

    btc_cam #(.N(NUM_ENTRIES), .AW(ADDR_W)) u_upd_cam (
        .valid (valid_q),
        .tags  (tag_q),
        .key   (upd_addr),
        .match (upd_match)
    );

    btc_enc #(.N(NUM_ENTRIES), .IW(IDX_W)) u_upd_enc (
        .onehot (upd_match),
        .idx    (upd_idx)
    );

    assign upd_hit  = |upd_match;
    assign upd_kind = btc_classify(upd_valid, upd_taken, upd_hit);

    btc_victim #(.N(NUM_ENTRIES), .IW(IDX_W)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .valid      (valid_q),
        .alloc      (upd_kind == UPD_ALLOC),
        .victim_idx (victim_idx),
        .rr_ptr     (rr_ptr)
    );

    // Lookup path: registered contents only, so same-cycle updates are unseen.
    assign lk_hit = |lk_match;
    always_comb begin
        lk_target = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (lk_match[i]) begin
                lk_target = lk_target | tgt_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            case (upd_kind)
                UPD_ALLOC: valid_q[victim_idx] <= 1'b1;
                UPD_DROP:  valid_q[upd_idx]    <= 1'b0;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        case (upd_kind)
            UPD_ALLOC: begin
                tag_q[victim_idx] <= upd_addr;
                tgt_q[victim_idx] <= upd_target;
            end
            UPD_REFRESH: tgt_q[upd_idx] <= upd_target;
            default: ;
        endcase
    end
endmodule

// File: rtl/btc_checker.sv
module btc_checker #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          upd_valid,
    input logic          upd_taken,
    input logic          upd_hit,
    input logic          lk_hit,
    input logic [N-1:0]  valid_q,
    input logic [N-1:0]  lk_match,
    input logic [IW-1:0] rr_ptr
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !lk_hit); // R1

    AST_NT_NO_GROW: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken && !upd_hit) |=> $stable(valid_q)); // R4

    AST_NT_DROPS_ONE: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken && upd_hit)
        |=> ($countones(valid_q) == $countones($past(valid_q)) - 1)); // R5

    AST_REFRESH_KEEPS_SET: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && upd_hit) |=> $stable(valid_q)); // R6

    AST_LOOKUP_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match)); // R6

    AST_FREE_ALLOC_GROWS: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && !upd_hit && !(&valid_q))
        |=> ($countones(valid_q) == $countones($past(valid_q)) + 1)
            && $stable(rr_ptr)); // R7

    AST_RR_STEP: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && !upd_hit && (&valid_q))
        |=> (rr_ptr == (($past(rr_ptr) == LAST) ? '0 : $past(rr_ptr) + 1'b1))); // R8
endmodule

bind btc_top btc_checker #(.N(NUM_ENTRIES), .IW(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .upd_hit   (upd_hit),
    .lk_hit    (lk_hit),
    .valid_q   (valid_q),
    .lk_match  (lk_match),
    .rr_ptr    (rr_ptr)
);

// File: tb/btc_top_tb.sv
module btc_top_tb;
    localparam int N  = 32;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_hit;
    logic [AW-1:0] lk_target;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_addr = '0;
    logic [AW-1:0] upd_target = '0;
    logic          upd_taken = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    btc_top #(.NUM_ENTRIES(N), .ADDR_W(AW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .lk_addr    (lk_addr),
        .lk_hit     (lk_hit),
        .lk_target  (lk_target),
        .upd_valid  (upd_valid),
        .upd_addr   (upd_addr),
        .upd_target (upd_target),
        .upd_taken  (upd_taken)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Combinational lookup, sampled away from the clock edge.
    task automatic look(input string req, input logic [AW-1:0] a,
                        input logic exp_hit, input logic [AW-1:0] exp_tgt);
        lk_addr = a;
        #0.5;
        chk({req, " hit"}, {31'd0, lk_hit}, {31'd0, exp_hit});
        if (exp_hit) chk({req, " target"}, lk_target, exp_tgt);
    endtask

    task automatic update(input logic [AW-1:0] a, input logic [AW-1:0] t, input logic tk);
        @(negedge clk);
        upd_valid  = 1'b1;
        upd_addr   = a;
        upd_target = t;
        upd_taken  = tk;
        @(negedge clk);
        upd_valid  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        look("R1", 32'h0000_0000, 1'b0, '0);
        look("R1", 32'h1000_0040, 1'b0, '0);
        look("R1", 32'hFFFF_FFFC, 1'b0, '0);
    endtask

    task automatic t_alloc();
        update(32'h0000_1000, 32'h0000_2000, 1'b1);
        look("R2", 32'h0000_1000, 1'b1, 32'h0000_2000);
        look("R10", 32'h0000_1001, 1'b0, '0);
        look("R10", 32'h8000_1000, 1'b0, '0);
        update(32'h0000_3000, 32'h0000_4444, 1'b1);
        // R3: two addresses within one clock period, no edge between them
        @(negedge clk);
        look("R3", 32'h0000_1000, 1'b1, 32'h0000_2000);
        look("R3", 32'h0000_3000, 1'b1, 32'h0000_4444);
        look("R3", 32'h0000_5000, 1'b0, '0);
    endtask

    task automatic t_not_taken();
        update(32'h0000_7000, 32'h0000_7777, 1'b0);
        look("R4", 32'h0000_7000, 1'b0, '0);
        look("R4", 32'h0000_1000, 1'b1, 32'h0000_2000);
        update(32'h0000_3000, 32'h0000_4444, 1'b0);
        look("R5", 32'h0000_3000, 1'b0, '0);
        look("R5", 32'h0000_1000, 1'b1, 32'h0000_2000);
    endtask

    task automatic t_refresh();
        update(32'h0000_1000, 32'h0000_2222, 1'b1);
        look("R6", 32'h0000_1000, 1'b1, 32'h0000_2222);
        update(32'h0000_1000, 32'h0000_0000, 1'b0);
        look("R6", 32'h0000_1000, 1'b0, '0);
    endtask

    task automatic t_same_cycle();
        update(32'h0000_9000, 32'h0000_A000, 1'b1);
        @(negedge clk);
        upd_valid = 1'b1; upd_addr = 32'h0000_9000;
        upd_target = 32'h0000_B000; upd_taken = 1'b1;
        look("R9", 32'h0000_9000, 1'b1, 32'h0000_A000);
        @(negedge clk);
        upd_valid = 1'b0;
        look("R9", 32'h0000_9000, 1'b1, 32'h0000_B000);
        upd_valid = 1'b1; upd_taken = 1'b0;
        look("R9", 32'h0000_9000, 1'b1, 32'h0000_B000);
        @(negedge clk);
        upd_valid = 1'b0;
        look("R9", 32'h0000_9000, 1'b0, '0);
    endtask

    task automatic t_replace();
        do_reset();
        for (int i = 0; i < N; i++) update(32'h0001_0000 + i, 32'h0002_0000 + i, 1'b1);
        for (int i = 0; i < N; i++) look("R8", 32'h0001_0000 + i, 1'b1, 32'h0002_0000 + i);
        update(32'h0003_0000, 32'h0004_0000, 1'b1);
        look("R8", 32'h0001_0000, 1'b0, '0);
        look("R8", 32'h0001_0001, 1'b1, 32'h0002_0001);
        look("R8", 32'h0003_0000, 1'b1, 32'h0004_0000);
        update(32'h0003_0001, 32'h0004_0001, 1'b1);
        look("R8", 32'h0001_0001, 1'b0, '0);
        look("R8", 32'h0001_0002, 1'b1, 32'h0002_0002);
        // R7: free slot at entry 5 is used, pointer stays at entry 2
        update(32'h0001_0005, 32'h0, 1'b0);
        update(32'h0005_0000, 32'h0006_0000, 1'b1);
        look("R7", 32'h0005_0000, 1'b1, 32'h0006_0000);
        look("R7", 32'h0001_0002, 1'b1, 32'h0002_0002);
        look("R7", 32'h0001_0006, 1'b1, 32'h0002_0006);
        update(32'h0005_0001, 32'h0006_0001, 1'b1);
        look("R7", 32'h0001_0002, 1'b0, '0);
        look("R7", 32'h0005_0000, 1'b1, 32'h0006_0000);
        look("R7", 32'h0005_0001, 1'b1, 32'h0006_0001);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        do_reset();
        t_reset();
        t_alloc();
        t_not_taken();
        t_refresh();
        t_same_cycle();
        t_replace();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #(5.0 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end
endmodule